// File: doc/BRIEF.md
# Sleep Instruction Gate

This block decides whether the processor core may act on its two sleep instructions, STOP and WAIT. Each instruction has its own lane with two independent disables. A soft disable is an ordinary flop that software may set and clear at will. A hard disable can only be set by a write: once it is set, no write can clear it, and only reset returns it to the clear state. The block tells the core that an instruction is allowed only when neither of its disables is set. This allowed signal is registered.

The same control word also holds a clock source select bit. This bit chooses whether the system clock comes from the prescaler or from the PLL. The block only stores the choice. The clock mux, the PLL and the core's sleep logic sit outside it. Nothing shuts the PLL down when the core enters STOP. Software must first move the system clock to the prescaler and only then power the PLL down.

Each lane's hard disable is a two-state machine. LOCK_OPEN is entered at reset. The transition LOCK_OPEN to LOCK_HELD is taken on a write that has that lane's hard bit at 1. LOCK_HELD has no exit other than reset, and every other condition holds the current state. Control word layout: bit 0 is the STOP soft disable, bit 1 is the WAIT soft disable, bit 2 is the STOP hard disable, bit 3 is the WAIT hard disable, and bit 4 is the clock select (0 = prescaler, 1 = PLL).

Top module: `sleep_gate`

## Requirements
- R1: After reset, `ctrl_rdata` reads 0, `stop_allowed` and `wait_allowed` are 1, and `clk_sel_pll` is 0 (prescaler).
- R2: A write loads bit 0 into the STOP soft disable and bit 1 into the WAIT soft disable. A later write can set or clear either bit, and the new value reads back on `ctrl_rdata` after the write edge.
- R3: A write with bit 2 (STOP) or bit 3 (WAIT) at 1 sets that hard disable.
- R4: Writing 0 to a hard disable bit that is already set has no effect. Only reset clears a hard disable.
- R5: When `wr_en` is 0, every stored bit keeps its value.
- R6: `stop_allowed` is the inverse of (STOP soft OR STOP hard) as read one cycle earlier. It therefore changes on the clock edge after the write edge.
- R7: `wait_allowed` follows the WAIT bits in the same way as R6, and it is independent of the STOP bits.
- R8: A write loads bit 4 into the clock select. `clk_sel_pll` and `ctrl_rdata[4]` show it, with 0 meaning prescaler and 1 meaning PLL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 5 | Control word write data |
| ctrl_rdata | output | 5 | Current value of the stored control bits |
| stop_allowed | output | 1 | Core may execute STOP (registered) |
| wait_allowed | output | 1 | Core may execute WAIT (registered) |
| clk_sel_pll | output | 1 | System clock source: 1 = PLL, 0 = prescaler |

## Verification
The bench builds the block with its default clock select reset value of 0, so the part comes out of reset running on the prescaler. With that value, a write of 1 to bit 4 shows the switch to the PLL, and a mid-run reset shows the return to the prescaler. The bench also combines soft and hard disables on each lane. It checks the one-cycle lag of the allowed outputs and that a zero write leaves a set hard disable in place.

// File: rtl/sleep_gate_pkg.sv
package sleep_gate_pkg;

    localparam int NUM_SLEEP  = 2;
    localparam int CTRL_W     = 2 * NUM_SLEEP + 1;
    localparam int SOFT_BASE  = 0;
    localparam int HARD_BASE  = NUM_SLEEP;
    localparam int CLKSEL_BIT = 2 * NUM_SLEEP;

    typedef enum logic {
        LOCK_OPEN = 1'b0,
        LOCK_HELD = 1'b1
    } lock_state_t;

endpackage

// File: rtl/sleep_lane.sv
module sleep_lane
    import sleep_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic soft_wr,
    input  logic hard_wr,
    output logic soft_q,
    output logic hard_q,
    output logic allowed_q
);

    lock_state_t state_q;
    lock_state_t state_d;

    // next state of the hard lock
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LOCK_OPEN: if (wr_en && hard_wr) state_d = LOCK_HELD;
            LOCK_HELD: state_d = LOCK_HELD;
            default:   state_d = LOCK_OPEN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LOCK_OPEN;
        else        state_q <= state_d;
    end

    assign hard_q = (state_q == LOCK_HELD);

    // soft disable and registered permission
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            soft_q    <= 1'b0;
            allowed_q <= 1'b1;
        end else begin
            if (wr_en) soft_q <= soft_wr;
            allowed_q <= !(soft_q || hard_q);
        end
    end

endmodule

// File: rtl/clk_src_reg.sv
module clk_src_reg #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic sel_wr,
    output logic sel_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sel_q <= RST_VAL;
        else if (wr_en) sel_q <= sel_wr;
    end

endmodule

// File: rtl/sleep_gate.sv
module sleep_gate
    import sleep_gate_pkg::*;
#(
    parameter logic CLKSEL_RST = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] ctrl_rdata,
    output logic              stop_allowed,
    output logic              wait_allowed,
    output logic              clk_sel_pll
);

    logic [NUM_SLEEP-1:0] soft_bits;
    logic [NUM_SLEEP-1:0] hard_bits;
    logic [NUM_SLEEP-1:0] allow_bits;

    // lane 0 = STOP, lane 1 = WAIT
    for (genvar g = 0; g < NUM_SLEEP; g++) begin : g_lane
        sleep_lane u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_en),
            .soft_wr   (wr_data[SOFT_BASE + g]),
            .hard_wr   (wr_data[HARD_BASE + g]),
            .soft_q    (soft_bits[g]),
            .hard_q    (hard_bits[g]),
            .allowed_q (allow_bits[g])
        );
    end

    clk_src_reg #(.RST_VAL(CLKSEL_RST)) u_clksel (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .sel_wr (wr_data[CLKSEL_BIT]),
        .sel_q  (clk_sel_pll)
    );

    assign ctrl_rdata   = {clk_sel_pll, hard_bits, soft_bits};
    assign stop_allowed = allow_bits[0];
    assign wait_allowed = allow_bits[1];

endmodule

// File: rtl/sleep_gate_chk.sv
module sleep_gate_chk
    import sleep_gate_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [CTRL_W-1:0] wr_data,
    input logic [CTRL_W-1:0] ctrl_rdata,
    input logic              stop_allowed,
    input logic              wait_allowed,
    input logic              clk_sel_pll
);

    a_r2_soft_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ctrl_rdata[1:0] == $past(wr_data[1:0]));

    a_r3_hard_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[2]) |=> ctrl_rdata[2]);

    a_r4_stop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rdata[2] |=> ctrl_rdata[2]);

    a_r4_wait_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rdata[3] |=> ctrl_rdata[3]);

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl_rdata));

    a_r6_stop_allowed: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> stop_allowed == !($past(ctrl_rdata[0]) || $past(ctrl_rdata[2])));

    a_r7_wait_allowed: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> wait_allowed == !($past(ctrl_rdata[1]) || $past(ctrl_rdata[3])));

    a_r8_clksel: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (clk_sel_pll == $past(wr_data[4])) && (ctrl_rdata[4] == clk_sel_pll));

endmodule

bind sleep_gate sleep_gate_chk u_sleep_gate_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .ctrl_rdata   (ctrl_rdata),
    .stop_allowed (stop_allowed),
    .wait_allowed (wait_allowed),
    .clk_sel_pll  (clk_sel_pll)
);

// File: tb/tb_sleep_gate.sv
`timescale 1ns/1ps
module tb_sleep_gate;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_data = '0;
    logic [4:0] ctrl_rdata;
    logic       stop_allowed;
    logic       wait_allowed;
    logic       clk_sel_pll;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    sleep_gate dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .ctrl_rdata   (ctrl_rdata),
        .stop_allowed (stop_allowed),
        .wait_allowed (wait_allowed),
        .clk_sel_pll  (clk_sel_pll)
    );

    task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // write at an edge; returns just after that edge (state updated, allowed not yet)
    task automatic wr(input logic [4:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = 5'h1f;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 rdata", ctrl_rdata, 5'b00000);
        chk("R1 allowed", {3'b0, stop_allowed, wait_allowed}, 5'b00011);
        chk("R1 clksel", {4'b0, clk_sel_pll}, 5'b0);
    endtask

    task automatic t_soft_stop();
        wr(5'b00001);
        chk("R2 stop soft set", ctrl_rdata, 5'b00001);
        chk("R6 stop allowed lags", {4'b0, stop_allowed}, 5'd1);
        @(negedge clk);
        chk("R6 stop blocked", {3'b0, stop_allowed, wait_allowed}, 5'b00001);
        wr(5'b00000);
        chk("R2 stop soft clear", ctrl_rdata, 5'b00000);
        @(negedge clk);
        chk("R6 stop reopened", {4'b0, stop_allowed}, 5'd1);
    endtask

    task automatic t_soft_wait();
        wr(5'b00010);
        chk("R2 wait soft set", ctrl_rdata, 5'b00010);
        @(negedge clk);
        chk("R7 wait blocked, stop free", {3'b0, stop_allowed, wait_allowed}, 5'b00010);
        wr(5'b00000);
        @(negedge clk);
        chk("R7 wait reopened", {4'b0, wait_allowed}, 5'd1);
    endtask

    task automatic t_idle();
        wr(5'b00011);
        // wr_data is 1f with wr_en low for several cycles
        repeat (3) @(negedge clk);
        chk("R5 held with no write", ctrl_rdata, 5'b00011);
        wr(5'b00000);
        @(negedge clk);
    endtask

    task automatic t_perm_stop();
        wr(5'b00100);
        chk("R3 stop hard set", ctrl_rdata, 5'b00100);
        @(negedge clk);
        chk("R6 stop hard blocks", {3'b0, stop_allowed, wait_allowed}, 5'b00001);
        wr(5'b00000);
        chk("R4 stop hard survives zero", ctrl_rdata, 5'b00100);
        @(negedge clk);
        chk("R4 stop still blocked", {4'b0, stop_allowed}, 5'd0);
        wr(5'b00001);
        wr(5'b00000);
        @(negedge clk);
        chk("R6 soft clear leaves hard", {4'b0, stop_allowed}, 5'd0);
    endtask

    task automatic t_perm_wait();
        wr(5'b01000);
        chk("R3 wait hard set", ctrl_rdata, 5'b01100);
        @(negedge clk);
        chk("R7 both blocked", {3'b0, stop_allowed, wait_allowed}, 5'b00000);
        wr(5'b00011);
        chk("R4 hard bits kept", ctrl_rdata, 5'b01111);
    endtask

    task automatic t_clksel();
        wr(5'b10000);
        chk("R8 pll selected", {4'b0, clk_sel_pll}, 5'd1);
        chk("R8 readback", ctrl_rdata, 5'b11100);
        wr(5'b00000);
        chk("R8 prescaler selected", {4'b0, clk_sel_pll}, 5'd0);
    endtask

    task automatic t_reset_clears();
        wr(5'b11111);
        do_reset();
        chk("R4 reset clears hard", ctrl_rdata, 5'b00000);
        chk("R1 allowed after reset", {3'b0, stop_allowed, wait_allowed}, 5'b00011);
        chk("R1 clksel after reset", {4'b0, clk_sel_pll}, 5'd0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_soft_stop();
        t_soft_wait();
        t_idle();
        t_perm_stop();
        t_perm_wait();
        t_clksel();
        t_reset_clears();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule